// File: doc/BRIEF.md
# End-Around-Carry Lookahead Adder

This block is the significand adder/subtractor of a floating-point add datapath. It takes two unsigned magnitudes and a control that selects add or subtract. Each magnitude is widened by one sign position at the top. For a subtract, the second operand is inverted bit by bit. The two words are then summed in one's-complement arithmetic, so the carry leaving the sign position re-enters at bit zero.

The block has no clock. The sum positions are split into 4-bit groups, and the topmost group holds the single leftover bit. Each group forms a generate and a propagate term. A cyclic lookahead network computes every group carry-in in one pass. Because the network wraps around, a generate in a high group can drive the carry into a low group, and no second ripple pass is needed for the end-around carry.

A small stage at the sign position turns the one's-complement word into a magnitude and two flags. A negative word is inverted to give its magnitude. The all-ones word (negative zero) becomes plain zero. An add that spills into the sign position is reported as overflow, not as a negative result. Normalization, rounding and exponent handling belong to neighbouring blocks.

Top module: `eac_lookahead_adder`

## Requirements
- R1: With sub_en=0, {res_ovf, res_mag} equals the full unsigned sum opa_mag + opb_mag, and res_ovf is the carry out of bit 23 of that sum.
- R2: With sub_en=1 and opa_mag > opb_mag, res_mag = opa_mag - opb_mag and res_neg = 0.
- R3: With sub_en=1 and opa_mag < opb_mag, res_mag = opb_mag - opa_mag and res_neg = 1.
- R4: With sub_en=1 and opa_mag = opb_mag, the one's-complement negative zero is mapped to res_mag = 0 with res_neg = 0.
- R5: res_ovf is never 1 when sub_en=1, and res_neg is never 1 when sub_en=0.
- R6: Carries that travel the full width through every group boundary are resolved correctly in both directions. This covers an add of all-ones plus one, and a subtract whose end-around carry must cross all groups.
- R7: An opb_mag of zero leaves opa_mag unchanged on res_mag under both add and subtract, with both flags at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_mag | input | 24 | First operand magnitude |
| opb_mag | input | 24 | Second operand magnitude |
| sub_en | input | 1 | 1 selects opa_mag - opb_mag, 0 selects the sum |
| res_mag | output | 24 | Result magnitude |
| res_neg | output | 1 | Result is negative (subtract with opb_mag larger) |
| res_ovf | output | 1 | Sum of two magnitudes carried into the sign position |

## Verification
The bound checker compares the result ports against an arithmetic statement of sum or absolute difference whenever the inputs change. The same checks cover the sign flag, the mapping of negative zero and the rule that the two flags never show up under the wrong operation. What the checker cannot show is that particular structural paths are exercised. The bench scenarios supply that: long carry chains across every group, wrap-around carries created in the top groups, operands at both ends of the range, and equal operands under subtraction.

// File: rtl/eac_pkg.sv
package eac_pkg;
    localparam int MAG_W_DEF = 24;
    localparam int GRP_W_DEF = 4;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/eac_group_pg.sv
// Bit and group generate/propagate for one lookahead group.
module eac_group_pg #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_bits,
    input  logic [W-1:0] b_bits,
    output logic [W-1:0] bit_p,
    output logic [W-1:0] bit_g,
    output logic         grp_g,
    output logic         grp_p
);
    always_comb begin
        logic term;
        bit_p = a_bits ^ b_bits;
        bit_g = a_bits & b_bits;
        grp_p = &bit_p;
        grp_g = 1'b0;
        for (int m = 0; m < W; m++) begin
            term = bit_g[m];
            for (int u = m + 1; u < W; u++) begin
                term = term & bit_p[u];
            end
            grp_g = grp_g | term;
        end
    end
endmodule

// File: rtl/eac_carry_ring.sv
// Cyclic lookahead: the carry into each group sees the generates of all groups,
// walking downward from the group just below it and wrapping past the top.
module eac_carry_ring #(
    parameter int N = 7
) (
    input  logic [N-1:0] grp_g,
    input  logic [N-1:0] grp_p,
    output logic [N-1:0] grp_cin
);
    always_comb begin
        logic term;
        int   src;
        int   mid;
        for (int k = 0; k < N; k++) begin
            grp_cin[k] = 1'b0;
            for (int j = 1; j <= N; j++) begin
                src  = (k - j + N) % N;
                term = grp_g[src];
                for (int m = 1; m < j; m++) begin
                    mid  = (k - m + N) % N;
                    term = term & grp_p[mid];
                end
                grp_cin[k] = grp_cin[k] | term;
            end
        end
    end
endmodule

// File: rtl/eac_group_sum.sv
// Sum bits of one group, internal carries by lookahead from the group carry-in.
module eac_group_sum #(
    parameter int W = 4
) (
    input  logic [W-1:0] bit_p,
    input  logic [W-1:0] bit_g,
    input  logic         cin,
    output logic [W-1:0] sum
);
    always_comb begin
        logic c;
        logic term;
        for (int i = 0; i < W; i++) begin
            c = cin;
            for (int u = 0; u < i; u++) begin
                c = c & bit_p[u];
            end
            for (int m = 0; m < i; m++) begin
                term = bit_g[m];
                for (int u = m + 1; u < i; u++) begin
                    term = term & bit_p[u];
                end
                c = c | term;
            end
            sum[i] = bit_p[i] ^ c;
        end
    end
endmodule

// File: rtl/eac_lookahead_adder.sv
module eac_lookahead_adder #(
    parameter int MAG_W = eac_pkg::MAG_W_DEF,
    parameter int GRP_W = eac_pkg::GRP_W_DEF
) (
    input  logic [MAG_W-1:0] opa_mag,
    input  logic [MAG_W-1:0] opb_mag,
    input  logic             sub_en,
    output logic [MAG_W-1:0] res_mag,
    output logic             res_neg,
    output logic             res_ovf
);
    localparam int SUM_W = MAG_W + 1;
    localparam int NGRP  = eac_pkg::ceil_div(SUM_W, GRP_W);

    logic [SUM_W-1:0] word_a;
    logic [SUM_W-1:0] word_b;
    logic [SUM_W-1:0] bit_p;
    logic [SUM_W-1:0] bit_g;
    logic [SUM_W-1:0] raw_sum;
    logic [NGRP-1:0]  grp_g;
    logic [NGRP-1:0]  grp_p;
    logic [NGRP-1:0]  grp_cin;

    // Sign extension, then bitwise inversion for subtract.
    assign word_a = {1'b0, opa_mag};
    assign word_b = sub_en ? ~{1'b0, opb_mag} : {1'b0, opb_mag};

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int LO  = k * GRP_W;
        localparam int HI  = ((LO + GRP_W) < SUM_W) ? (LO + GRP_W - 1) : (SUM_W - 1);
        localparam int WID = HI - LO + 1;

        eac_group_pg #(.W(WID)) pg_i (
            .a_bits (word_a[HI:LO]),
            .b_bits (word_b[HI:LO]),
            .bit_p  (bit_p[HI:LO]),
            .bit_g  (bit_g[HI:LO]),
            .grp_g  (grp_g[k]),
            .grp_p  (grp_p[k])
        );

        eac_group_sum #(.W(WID)) sum_i (
            .bit_p (bit_p[HI:LO]),
            .bit_g (bit_g[HI:LO]),
            .cin   (grp_cin[k]),
            .sum   (raw_sum[HI:LO])
        );
    end

    eac_carry_ring #(.N(NGRP)) ring_i (
        .grp_g   (grp_g),
        .grp_p   (grp_p),
        .grp_cin (grp_cin)
    );

    // Sign-position stage: overflow for sums, sign and magnitude for differences.
    always_comb begin
        logic neg_zero;
        neg_zero = &raw_sum;
        res_ovf  = raw_sum[SUM_W-1] & ~sub_en;
        res_neg  = raw_sum[SUM_W-1] & sub_en & ~neg_zero;
        if (sub_en && neg_zero) begin
            res_mag = '0;
        end else if (res_neg) begin
            res_mag = ~raw_sum[MAG_W-1:0];
        end else begin
            res_mag = raw_sum[MAG_W-1:0];
        end
    end
endmodule

// File: rtl/eac_adder_chk.sv
module eac_adder_chk #(
    parameter int MAG_W = 24
) (
    input logic [MAG_W-1:0] opa_mag,
    input logic [MAG_W-1:0] opb_mag,
    input logic             sub_en,
    input logic [MAG_W-1:0] res_mag,
    input logic             res_neg,
    input logic             res_ovf
);
    always_comb begin
        if (!$isunknown({opa_mag, opb_mag, sub_en, res_mag, res_neg, res_ovf})) begin
            AST_ADD_VALUE: assert (sub_en || ({res_ovf, res_mag} == ({1'b0, opa_mag} + {1'b0, opb_mag}))) else $error("add value"); // R1
            AST_SUB_GT: assert (!(sub_en && opa_mag > opb_mag) || (res_mag == opa_mag - opb_mag && !res_neg)) else $error("sub gt"); // R2
            AST_SUB_LT: assert (!(sub_en && opa_mag < opb_mag) || (res_mag == opb_mag - opa_mag && res_neg)) else $error("sub lt"); // R3
            AST_NEG_ZERO: assert (!(sub_en && opa_mag == opb_mag) || (res_mag == '0 && !res_neg)) else $error("neg zero"); // R4
            AST_SUB_NO_OVF: assert (!(sub_en && res_ovf)) else $error("ovf in sub"); // R5
            AST_ADD_NO_NEG: assert (!(!sub_en && res_neg)) else $error("neg in add"); // R5
        end
    end
endmodule

bind eac_lookahead_adder eac_adder_chk #(.MAG_W(MAG_W)) chk_i (
    .opa_mag (opa_mag),
    .opb_mag (opb_mag),
    .sub_en  (sub_en),
    .res_mag (res_mag),
    .res_neg (res_neg),
    .res_ovf (res_ovf)
);

// File: tb/eac_lookahead_adder_tb_top.sv
`timescale 1ns/1ps
module eac_lookahead_adder_tb_top;
    localparam int MAG_W = 24;
    localparam logic [MAG_W-1:0] ONES = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [MAG_W-1:0] opa_mag = '0;
    logic [MAG_W-1:0] opb_mag = '0;
    logic             sub_en = 1'b0;
    logic [MAG_W-1:0] res_mag;
    logic             res_neg;
    logic             res_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    eac_lookahead_adder #(.MAG_W(MAG_W)) dut_i (
        .opa_mag (opa_mag),
        .opb_mag (opb_mag),
        .sub_en  (sub_en),
        .res_mag (res_mag),
        .res_neg (res_neg),
        .res_ovf (res_ovf)
    );

    // Behavioural reference on integers: sum, or signed difference split into sign and size.
    task automatic run(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b,
                       input logic s, input string req);
        longint ia;
        longint ib;
        longint ref_val;
        logic [MAG_W-1:0] exp_mag;
        logic exp_neg;
        logic exp_ovf;
        @(posedge clk);
        opa_mag = a;
        opb_mag = b;
        sub_en  = s;
        ia = longint'(a);
        ib = longint'(b);
        if (!s) begin
            ref_val = ia + ib;
            exp_mag = MAG_W'(ref_val);
            exp_ovf = ref_val >= (longint'(1) << MAG_W);
            exp_neg = 1'b0;
        end else begin
            ref_val = ia - ib;
            exp_neg = ref_val < 0;
            exp_mag = MAG_W'(exp_neg ? -ref_val : ref_val);
            exp_ovf = 1'b0;
        end
        @(negedge clk);
        checks++;
        if (res_mag !== exp_mag || res_neg !== exp_neg || res_ovf !== exp_ovf) begin
            failures++;
            $display("FAIL %s a=%h b=%h sub=%0b actual mag=%h neg=%0b ovf=%0b expected mag=%h neg=%0b ovf=%0b",
                     req, a, b, s, res_mag, res_neg, res_ovf, exp_mag, exp_neg, exp_ovf);
        end
    endtask

    function automatic string tag_of(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b,
                                     input logic s);
        if (!s) return "R1";
        if (a > b) return "R2";
        if (a < b) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        run('0, '0, 1'b0, "R1 reset-state zero");
        run(24'h000123, 24'h000456, 1'b0, "R1");
        run(ONES, ONES, 1'b0, "R1 max overflow");
        run(24'h800000, 24'h800000, 1'b0, "R1 top bit overflow");
        run(24'h000500, 24'h000123, 1'b1, "R2");
        run(ONES, 24'h000001, 1'b1, "R2 max minus one");
        run(24'h000123, 24'h000500, 1'b1, "R3");
        run('0, ONES, 1'b1, "R3 zero minus max");
        run(24'h5A5A5A, 24'h5A5A5A, 1'b1, "R4");
        run('0, '0, 1'b1, "R4 zero minus zero");
        run(ONES, ONES, 1'b1, "R4 max minus max");
        run(ONES, 24'h000001, 1'b0, "R6 full carry chain add");
        run(24'h000001, 24'h000000, 1'b1, "R6 wrap carry through all groups");
        run(24'h800000, 24'h7FFFFF, 1'b1, "R6 difference one across groups");
        run(24'h7FFFFF, 24'h800000, 1'b1, "R6 r5_ negative one");
        run(24'h0F0F0F, 24'h0F0F0F, 1'b0, "R6");
        run(24'hABCDEF, '0, 1'b0, "R7 add zero");
        run(24'hABCDEF, '0, 1'b1, "R7 sub zero");
        for (int i = 0; i < 600; i++) begin
            logic [MAG_W-1:0] a;
            logic [MAG_W-1:0] b;
            logic s;
            a = MAG_W'($urandom);
            b = MAG_W'($urandom);
            s = 1'($urandom);
            if (i % 10 == 0) b = a;
            if (i % 10 == 1) b = a ^ MAG_W'(1 << (i % MAG_W));
            run(a, b, s, tag_of(a, b, s));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule